// File: doc/BRIEF.md
# CPU Clock Stop and Power-Down Gating Controller

This block sits between free-running source clocks and the clock output stage. It has two active-low controls. The first is a stop request that halts only the CPU clock outputs. The second is a power-down request that silences every clock group and turns off the oscillator/PLL enable. The CPU clock outputs are a true clock, an open-drain-style copy and a complementary clock with its own output enable.

The stop request is first captured by two flops clocked by the PCI clock. It is then carried into the CPU clock domain by a second pair of flops. The final gate enable is captured on the falling CPU edge and ANDed with the source clock. Every stop therefore ends after a complete high phase, and every restart begins with a rising edge.

Power-down clears all state at once. When power-down is released, a counter in the reference-clock domain stands in for oscillator lock time. The PCI, SDRAM, 48 MHz and reference group enables rise only after this counter expires, and the CPU clocks can start only after that.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `pwr_dn_n_i` is low, the following hold at once and regardless of `stop_n_i`: `cpu_clk_o` and `cpu_od_o` are low, `cpu_clk_b_oe_o` is low, all four group enables are low, `osc_en_o` is low, and `cpu_stopped_o` is high.
- R2: `osc_en_o` is high whenever `pwr_dn_n_i` is high, with no clock delay.
- R3: After `pwr_dn_n_i` rises, the four group enables stay low through the first SETTLE_CYCLES+1 rising edges of `ref_clk_i`. They rise at rising edge SETTLE_CYCLES+2 and stay high until the next power-down.
- R4: The CPU clocks stay stopped until the group enables are high. After that, with `stop_n_i` high, they start running.
- R5: Let `stop_n_i` fall and be held low, and count from the second `pci_clk_i` rising edge after the change. From that edge, `cpu_clk_o` gives 1 to 3 further high pulses and then stays low, and `cpu_stopped_o` goes high. A stop request present when power-down is released is honoured once the groups settle.
- R6: Let `stop_n_i` rise and be held high, and count from the second `pci_clk_i` rising edge after the change. From that edge, 1 to 3 rising edges of `cpu_clk_i` pass with `cpu_clk_o` low. The next rising edge of `cpu_clk_i` is the first transition of `cpu_clk_o`, and that transition is a rise.
- R7: Outside power-down, every high pulse of `cpu_clk_o` lasts a full high phase of `cpu_clk_i`, and `cpu_clk_o` only rises while `cpu_clk_i` is high.
- R8: `cpu_od_o` always equals `cpu_clk_o`, and `cpu_clk_b_o` is its inverse. `cpu_clk_b_oe_o` is high exactly when `cpu_stopped_o` is low. So a stopped complementary output is released to high impedance and held at its high level.
- R9: A stop request alone leaves the group enables and `osc_en_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | Free-running CPU source clock |
| pci_clk_i | input | 1 | Free-running PCI clock; samples the stop request |
| ref_clk_i | input | 1 | Free-running reference clock; times the settle period |
| stop_n_i | input | 1 | CPU clock stop request, active low |
| pwr_dn_n_i | input | 1 | Global power-down, active low; asynchronous clear |
| cpu_clk_o | output | 1 | Gated true CPU clock |
| cpu_od_o | output | 1 | Gated open-drain-style CPU clock |
| cpu_clk_b_o | output | 1 | Complementary CPU clock level |
| cpu_clk_b_oe_o | output | 1 | Output enable for the complementary CPU clock |
| pci_en_o | output | 1 | PCI clock group enable |
| sdram_en_o | output | 1 | SDRAM clock group enable |
| clk48_en_o | output | 1 | 48 MHz clock group enable |
| ref_en_o | output | 1 | Reference clock group enable |
| osc_en_o | output | 1 | Oscillator and PLL enable |
| cpu_stopped_o | output | 1 | High while the CPU clocks are held stopped |

## Verification
The assertions assume that the three source clocks keep toggling during power-down. They also assume that `stop_n_i` changes well away from a `pci_clk_i` rising edge, and that `pwr_dn_n_i` stays low for more than one clock period. The stimulus enforces all three. It runs fixed clocks whose rising edges never coincide. It changes the stop request a random 1 to 10 ns after a PCI rising edge within a 12 ns period. It holds power-down for many reference cycles. Random run and stop durations come from a fixed seed. Directed cases cover a power-down that cuts a high phase, and a power-down released while the stop request is already active.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  // Width needed to hold the values 0..limit.
  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // Saturating increment used by the settle counter.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/clkstop_sync2.sv
`timescale 1ns/1ps
module clkstop_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sr_q <= '0;
    else           sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/clkstop_settle.sv
`timescale 1ns/1ps
module clkstop_settle #(
  parameter int unsigned SETTLE_CYCLES = 16
) (
  input  logic ref_clk_i,
  input  logic pd_n_i,
  output logic groups_on_o
);
  import clkstop_pkg::*;

  localparam int unsigned CW = cnt_bits(SETTLE_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

  logic          rel_q;
  logic [CW-1:0] cnt_q;

  // Release of power-down is retimed before counting starts.
  clkstop_sync2 #(.STAGES(2)) u_rel_sync (
    .clk_i   (ref_clk_i),
    .arst_n_i(pd_n_i),
    .d_i     (1'b1),
    .q_o     (rel_q)
  );

  always_ff @(posedge ref_clk_i or negedge pd_n_i) begin
    if (!pd_n_i)    cnt_q <= '0;
    else if (rel_q) cnt_q <= CW'(sat_inc(32'(cnt_q), SETTLE_CYCLES));
  end

  assign groups_on_o = (cnt_q == LIMIT);

  p_settle_bound_r3: assert property (@(posedge ref_clk_i) disable iff (!pd_n_i)
    cnt_q <= LIMIT);

  p_groups_hold_r3: assert property (@(posedge ref_clk_i) disable iff (!pd_n_i)
    groups_on_o |=> groups_on_o);
endmodule

// File: rtl/clkstop_cpu_gate.sv
`timescale 1ns/1ps
module clkstop_cpu_gate (
  input  logic cpu_clk_i,
  input  logic pd_n_i,
  input  logic run_req_i,
  output logic cpu_clk_o,
  output logic cpu_od_o,
  output logic cpu_clk_b_o,
  output logic cpu_clk_b_oe_o,
  output logic stopped_o
);
  logic [1:0] run_sr_q;
  logic       run_pre;
  logic       run_sync;
  logic       gate_on_q;

  // Two-flop retiming of the PCI-domain run request.
  always_ff @(posedge cpu_clk_i or negedge pd_n_i) begin
    if (!pd_n_i) run_sr_q <= '0;
    else         run_sr_q <= {run_sr_q[0], run_req_i};
  end

  assign run_pre  = run_sr_q[0];
  assign run_sync = run_sr_q[1];

  // Enable changes only while the source clock is low.
  always_ff @(negedge cpu_clk_i or negedge pd_n_i) begin
    if (!pd_n_i) gate_on_q <= 1'b0;
    else         gate_on_q <= run_sync;
  end

  assign cpu_clk_o      = cpu_clk_i & gate_on_q;
  assign cpu_od_o       = cpu_clk_o;
  assign cpu_clk_b_o    = ~cpu_clk_o;
  assign cpu_clk_b_oe_o = gate_on_q;
  assign stopped_o      = ~gate_on_q;

  p_restart_path_r6: assert property (@(posedge cpu_clk_i) disable iff (!pd_n_i)
    $rose(gate_on_q) |-> $past(run_pre));

  p_stop_path_r5: assert property (@(posedge cpu_clk_i) disable iff (!pd_n_i)
    $fell(gate_on_q) |-> !$past(run_pre));

  always @(negedge cpu_clk_i) begin
    if (!pd_n_i) begin
      p_pd_quiet_r1: assert (!cpu_clk_o && !cpu_clk_b_oe_o && stopped_o);
    end
  end
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl #(
  parameter int unsigned SETTLE_CYCLES = 16
) (
  input  logic cpu_clk_i,
  input  logic pci_clk_i,
  input  logic ref_clk_i,
  input  logic stop_n_i,
  input  logic pwr_dn_n_i,
  output logic cpu_clk_o,
  output logic cpu_od_o,
  output logic cpu_clk_b_o,
  output logic cpu_clk_b_oe_o,
  output logic pci_en_o,
  output logic sdram_en_o,
  output logic clk48_en_o,
  output logic ref_en_o,
  output logic osc_en_o,
  output logic cpu_stopped_o
);
  logic groups_on;
  logic pci_run;

  clkstop_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .ref_clk_i  (ref_clk_i),
    .pd_n_i     (pwr_dn_n_i),
    .groups_on_o(groups_on)
  );

  // Stop request sampled on PCI rising edges; no run before settle.
  clkstop_sync2 #(.STAGES(2)) u_pci_sync (
    .clk_i   (pci_clk_i),
    .arst_n_i(pwr_dn_n_i),
    .d_i     (stop_n_i & groups_on),
    .q_o     (pci_run)
  );

  clkstop_cpu_gate u_cpu_gate (
    .cpu_clk_i     (cpu_clk_i),
    .pd_n_i        (pwr_dn_n_i),
    .run_req_i     (pci_run),
    .cpu_clk_o     (cpu_clk_o),
    .cpu_od_o      (cpu_od_o),
    .cpu_clk_b_o   (cpu_clk_b_o),
    .cpu_clk_b_oe_o(cpu_clk_b_oe_o),
    .stopped_o     (cpu_stopped_o)
  );

  assign pci_en_o   = groups_on;
  assign sdram_en_o = groups_on;
  assign clk48_en_o = groups_on;
  assign ref_en_o   = groups_on;
  assign osc_en_o   = pwr_dn_n_i;

  p_cpu_after_settle_r4: assert property (@(posedge pci_clk_i) disable iff (!pwr_dn_n_i)
    $rose(pci_run) |-> groups_on);
endmodule

// File: tb/clkstop_ctrl_tb.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb;
  localparam int unsigned SETTLE = 6;

  logic cpu_clk = 1'b0, pci_clk = 1'b0, ref_clk = 1'b0;
  logic stop_n = 1'b1, pwr_dn_n = 1'b1;
  logic cpu_clk_o, cpu_od_o, cpu_clk_b_o, cpu_clk_b_oe_o;
  logic pci_en_o, sdram_en_o, clk48_en_o, ref_en_o, osc_en_o, cpu_stopped_o;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  longint hi_t = 0;

  clkstop_ctrl #(.SETTLE_CYCLES(SETTLE)) u_dut (
    .cpu_clk_i(cpu_clk), .pci_clk_i(pci_clk), .ref_clk_i(ref_clk),
    .stop_n_i(stop_n), .pwr_dn_n_i(pwr_dn_n),
    .cpu_clk_o(cpu_clk_o), .cpu_od_o(cpu_od_o), .cpu_clk_b_o(cpu_clk_b_o),
    .cpu_clk_b_oe_o(cpu_clk_b_oe_o), .pci_en_o(pci_en_o), .sdram_en_o(sdram_en_o),
    .clk48_en_o(clk48_en_o), .ref_en_o(ref_en_o), .osc_en_o(osc_en_o),
    .cpu_stopped_o(cpu_stopped_o)
  );

  // 250 MHz CPU clock: edges at even ns. PCI and reference rise at odd ns.
  always #2 cpu_clk = ~cpu_clk;
  initial begin #3; forever begin pci_clk = 1'b1; #6; pci_clk = 1'b0; #6; end end
  initial begin #5; forever begin ref_clk = 1'b1; #15; ref_clk = 1'b0; #15; end end

  function automatic bit lat_ok(input int n);
    return (n >= 1) && (n <= 3);
  endfunction

  function automatic int settle_edge(input int s);
    return s + 2;
  endfunction

  function automatic int groups_val();
    return {28'd0, pci_en_o, sdram_en_o, clk48_en_o, ref_en_o};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_pd_state(input string req);
    chk(!cpu_clk_o && !cpu_od_o, req, "cpu clocks low", int'(cpu_clk_o), 0);
    chk(!cpu_clk_b_oe_o, req, "comp oe low", int'(cpu_clk_b_oe_o), 0);
    chk(groups_val() == 0, req, "group enables", groups_val(), 0);
    chk(!osc_en_o, req, "osc enable", int'(osc_en_o), 0);
    chk(cpu_stopped_o, req, "stopped flag", int'(cpu_stopped_o), 1);
  endtask

  task automatic power_up();
    int early;
    early = 0;
    @(posedge ref_clk); #4;
    pwr_dn_n = 1'b1;
    #1 chk(osc_en_o, "R2", "osc enable on release", int'(osc_en_o), 1);
    for (int i = 1; i < settle_edge(SETTLE); i++) begin
      @(posedge ref_clk); #1;
      if (groups_val() != 0) early++;
    end
    chk(early == 0, "R3", "enables early", early, 0);
    @(posedge ref_clk); #1;
    chk(groups_val() == 15, "R3", "enables at settle edge", groups_val(), 15);
    chk(cpu_stopped_o, "R4", "cpu stopped at settle", int'(cpu_stopped_o), 1);
  endtask

  task automatic wait_running();
    int k;
    k = 0;
    while (cpu_stopped_o && k < 40) begin @(posedge cpu_clk); #1; k++; end
    chk(!cpu_stopped_o, "R4", "cpu started after settle", int'(cpu_stopped_o), 0);
  endtask

  task automatic do_stop(input int offs);
    int n;
    n = 0;
    @(posedge pci_clk); #(offs);
    stop_n = 1'b0;
    @(posedge pci_clk); @(posedge pci_clk);
    for (int k = 0; k < 8; k++) begin
      @(posedge cpu_clk); #1;
      if (cpu_clk_o) n++; else break;
    end
    chk(lat_ok(n), "R5", "pulses after stop", n, 2);
    chk(cpu_stopped_o, "R5", "stopped flag", int'(cpu_stopped_o), 1);
    repeat (3) @(posedge cpu_clk);
    #1 chk(!cpu_clk_o && cpu_stopped_o, "R5", "stays stopped", int'(cpu_clk_o), 0);
    chk(groups_val() == 15 && osc_en_o, "R9", "groups run during stop",
        groups_val(), 15);
  endtask

  task automatic do_start(input int offs);
    int n;
    n = 0;
    @(posedge pci_clk); #(offs);
    stop_n = 1'b1;
    @(posedge pci_clk); @(posedge pci_clk);
    for (int k = 0; k < 8; k++) begin
      @(posedge cpu_clk); #1;
      if (!cpu_clk_o) n++; else break;
    end
    chk(lat_ok(n), "R6", "skipped cycles before restart", n, 2);
    chk(!cpu_stopped_o && cpu_clk_o, "R6", "running after restart",
        int'(cpu_clk_o), 1);
  endtask

  // R7: full-width high pulses that rise only with the source clock.
  always @(posedge cpu_clk_o) begin
    hi_t = $time;
    if (pwr_dn_n) chk(cpu_clk == 1'b1, "R7", "rise with source", int'(cpu_clk), 1);
  end
  always @(negedge cpu_clk_o) begin
    if (pwr_dn_n) chk(($time - hi_t) == 2, "R7", "high width ns", int'($time - hi_t), 2);
  end

  // R8: output relations checked mid-phase every cycle.
  always @(posedge cpu_clk) begin
    #1;
    chk(cpu_od_o == cpu_clk_o && cpu_clk_b_o == !cpu_clk_o, "R8", "od and comp",
        int'({cpu_od_o, cpu_clk_b_o}), int'({cpu_clk_o, !cpu_clk_o}));
    chk(cpu_clk_b_oe_o == !cpu_stopped_o, "R8", "comp oe", int'(cpu_clk_b_oe_o),
        int'(!cpu_stopped_o));
  end

  initial begin
    void'($urandom(32'd20240611));
    #1 pwr_dn_n = 1'b0;
    #40 check_pd_state("R1");
    chk(stop_n, "R1", "stimulus sanity", int'(stop_n), 1);
    power_up();
    wait_running();

    for (int it = 0; it < 12; it++) begin
      repeat ($urandom_range(20, 5)) @(posedge cpu_clk);
      do_stop($urandom_range(10, 1));
      repeat ($urandom_range(20, 5)) @(posedge cpu_clk);
      do_start($urandom_range(10, 1));
    end

    // Power-down cutting a high phase while running.
    @(posedge cpu_clk); #1;
    pwr_dn_n = 1'b0;
    #0.5 check_pd_state("R1");
    stop_n = 1'b0;
    repeat (10) @(posedge ref_clk);
    #1 check_pd_state("R1");

    // Release with stop already active: stays stopped after settle.
    power_up();
    repeat (30) @(posedge cpu_clk);
    #1 chk(cpu_stopped_o && !cpu_clk_o, "R5", "stop honoured after settle",
           int'(cpu_stopped_o), 1);
    chk(groups_val() == 15, "R9", "groups with stop only", groups_val(), 15);
    do_start(5);
    repeat (10) @(posedge cpu_clk);
    do_stop(2);
    do_start(9);

    repeat (5) @(posedge cpu_clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule